// File: doc/BRIEF.md
# Quadrature-Modulated Numerically Controlled Oscillator

This block is a digital oscillator core that feeds a 10-bit DAC. A 32-bit phase register grows by a tuning word on every clock. The word comes from one of two inputs, and a select pin picks between them cycle by cycle, so frequency-shift keying costs nothing extra. The top bits of the phase get a 12-bit offset added to them, which gives phase modulation. The sum addresses a sine table and a cosine table that are built from one stored quadrant.

Each table output is multiplied by its own signed amplitude word. The two products are added, rounded, clipped and turned into an offset-binary DAC code. With the amplitude words driven as an in-phase/quadrature pair, the core produces QAM or single-sideband signals. A sleep input freezes the whole pipeline in place.

Top module: `qdds_core`

## Requirements
- R1: While reset is low, `dac_code` reads 512 and every pipeline stage is cleared. After release the phase starts from zero.
- R2: On every non-sleeping clock the phase grows by `fword0` when `fsel` is 0 and by `fword1` when `fsel` is 1, modulo 2^32.
- R3: The table address is the top 12 bits of the phase plus `phase_off`, modulo 4096.
- R4: Quadrant entry k (k = 0..1023) holds round(16*511*a / (5*4096^2 - 4*a)), where a = (2k+1)*(4096-(2k+1)). Address bits 11:10 select the quadrant: 0 gives +T[k], 1 gives +T[1023-k], 2 gives -T[k], 3 gives -T[1023-k]. Cosine is the sine taken at address + 1024.
- R5: `iq_amp[19:10]` is a signed word that scales the sine. `iq_amp[9:0]` is a signed word that scales the cosine.
- R6: The output value is y = floor((sin*As + cos*Ac + 256) / 512).
- R7: y is clipped to the range -512..511, so an overflow gives code 1023 and an underflow gives code 0.
- R8: `dac_code` = y + 512 (offset binary). Zero amplitude on both paths gives 512.
- R9: A change on `fsel` or on the tuning words first shows on `dac_code` 4 clocks later. A change on `phase_off` shows 3 clocks later, and a change on `iq_amp` shows 2 clocks later.
- R10: While `sleep` is high, no stage updates and `dac_code` holds its value. Operation resumes from the frozen state when `sleep` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep | input | 1 | Freezes every stage while high |
| fsel | input | 1 | Tuning word select, 0 = `fword0`, 1 = `fword1` |
| fword0 | input | 32 | Tuning word A |
| fword1 | input | 32 | Tuning word B |
| phase_off | input | 12 | Phase offset added to the top of the phase |
| iq_amp | input | 20 | Signed sine scale in the upper half, signed cosine scale in the lower half |
| dac_code | output | 10 | Offset-binary sample for the DAC |

## Verification
The properties assume that reset is held low for at least one clock at start-up, and that the inputs change only between clock edges. The zero-amplitude property also assumes `sleep` stays low across the two cycles that the amplitude takes to reach the output. The stimulus drives every input on the falling edge. It keeps `sleep` low during the amplitude and latency windows it measures. It returns the phase to a known zero through reset before each group of hand-computed checks.

// File: rtl/qdds_pkg.sv
package qdds_pkg;

  // Quadrant label taken from the two top address bits
  typedef enum logic [1:0] {
    Q_RISE   = 2'd0,
    Q_CREST  = 2'd1,
    Q_FALL   = 2'd2,
    Q_TROUGH = 2'd3
  } quad_e;

  // Rational sine approximation sampled at half-step centres of one quadrant.
  // n entries per quadrant, peak is the full-scale magnitude.
  function automatic int quad_sine(int k, int n, int peak);
    longint h;
    longint u;
    longint a;
    longint num;
    longint den;
    h   = 4 * longint'(n);
    u   = 2 * longint'(k) + 1;
    a   = u * (h - u);
    num = 16 * longint'(peak) * a;
    den = 5 * h * h - 4 * a;
    return int'((2 * num + den) / (2 * den));
  endfunction

  // Round half up, then drop sh fraction bits (arithmetic, floor)
  function automatic longint round_shift(longint v, int sh);
    longint half;
    half = longint'(1) <<< (sh - 1);
    return (v + half) >>> sh;
  endfunction

  // Clip to a w-bit signed range
  function automatic longint clip_signed(longint v, int w);
    longint hi;
    longint lo;
    hi = (longint'(1) <<< (w - 1)) - 1;
    lo = -(longint'(1) <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

endpackage

// File: rtl/qdds_phase_acc.sv
module qdds_phase_acc
  import qdds_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int PH_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             fsel,
  input  logic [ACC_W-1:0] fw0,
  input  logic [ACC_W-1:0] fw1,
  input  logic [PH_W-1:0]  ph_off,
  output logic [ACC_W-1:0] acc_q,
  output logic [PH_W-1:0]  addr_q
);

  // Selected step for this cycle
  logic [ACC_W-1:0] step_w;
  logic [ACC_W-1:0] acc_next;
  logic [PH_W-1:0]  phase_top;
  logic [PH_W-1:0]  addr_next;

  assign step_w    = fsel ? fw1 : fw0;
  assign acc_next  = acc_q + step_w;
  assign phase_top = acc_q[ACC_W-1 -: PH_W];
  assign addr_next = phase_top + ph_off;

  // Stage 1: accumulate
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (en) begin
      acc_q <= acc_next;
    end
  end

  // Stage 2: offset and truncate to table address
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (en) begin
      addr_q <= addr_next;
    end
  end

endmodule

// File: rtl/qdds_sincos_lut.sv
module qdds_sincos_lut
  import qdds_pkg::*;
#(
  parameter int PH_W = 12,
  parameter int SW   = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [PH_W-1:0]      addr,
  output logic signed [SW-1:0] sin_q,
  output logic signed [SW-1:0] cos_q
);

  localparam int KW   = PH_W - 2;
  localparam int QN   = 1 << KW;
  localparam int PEAK = (1 << (SW - 1)) - 1;
  localparam int NP   = 2;

  // One stored quadrant, computed at elaboration
  logic signed [SW-1:0] quad_tbl [QN];

  for (genvar g = 0; g < QN; g++) begin : g_tbl
    localparam int ENTRY = quad_sine(g, QN, PEAK);
    assign quad_tbl[g] = SW'(ENTRY);
  end

  // Port 0 reads sine, port 1 reads cosine (quarter turn ahead)
  logic [PH_W-1:0]      port_addr [NP];
  logic signed [SW-1:0] port_val  [NP];

  assign port_addr[0] = addr;
  assign port_addr[1] = addr + PH_W'(QN);

  for (genvar p = 0; p < NP; p++) begin : g_port
    quad_e                quad;
    logic [KW-1:0]        k_raw;
    logic [KW-1:0]        k_idx;
    logic                 mirror;
    logic                 negate;
    logic signed [SW-1:0] mag;

    assign quad   = quad_e'(port_addr[p][PH_W-1 -: 2]);
    assign k_raw  = port_addr[p][KW-1:0];
    assign mirror = (quad == Q_CREST) || (quad == Q_TROUGH);
    assign negate = (quad == Q_FALL)  || (quad == Q_TROUGH);
    assign k_idx  = mirror ? ~k_raw : k_raw;
    assign mag    = quad_tbl[k_idx];
    assign port_val[p] = negate ? -mag : mag;
  end

  // Stage 3: registered table outputs
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sin_q <= '0;
      cos_q <= '0;
    end else if (en) begin
      sin_q <= port_val[0];
      cos_q <= port_val[1];
    end
  end

endmodule

// File: rtl/qdds_iq_mix.sv
module qdds_iq_mix
  import qdds_pkg::*;
#(
  parameter int SW = 10,
  parameter int AW = 10,
  parameter int OW = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [SW-1:0] sin_in,
  input  logic signed [SW-1:0] cos_in,
  input  logic [AW-1:0]        amp_s,
  input  logic [AW-1:0]        amp_c,
  output logic [OW-1:0]        dac_q,
  output logic                 sat_hi,
  output logic                 sat_lo
);

  localparam int     PW    = SW + AW;
  localparam int     SUMW  = PW + 1;
  localparam int     SHIFT = SW + AW - OW - 1;
  localparam longint YMAX  = (longint'(1) <<< (OW - 1)) - 1;
  localparam longint YMIN  = -(longint'(1) <<< (OW - 1));
  localparam longint MID   = longint'(1) <<< (OW - 1);

  // Stage 3: amplitude words aligned with the table outputs
  logic signed [AW-1:0] amp_s_q;
  logic signed [AW-1:0] amp_c_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      amp_s_q <= '0;
      amp_c_q <= '0;
    end else if (en) begin
      amp_s_q <= $signed(amp_s);
      amp_c_q <= $signed(amp_c);
    end
  end

  logic signed [PW-1:0]   prod_s;
  logic signed [PW-1:0]   prod_c;
  logic signed [SUMW-1:0] sum_w;
  longint                 scaled;
  longint                 clipped;
  logic [OW-1:0]          code_d;

  assign prod_s = sin_in * amp_s_q;
  assign prod_c = cos_in * amp_c_q;
  assign sum_w  = SUMW'(prod_s) + SUMW'(prod_c);

  always_comb begin
    scaled  = round_shift(longint'(sum_w), SHIFT);
    clipped = clip_signed(scaled, OW);
    sat_hi  = (scaled > YMAX);
    sat_lo  = (scaled < YMIN);
    code_d  = OW'(clipped + MID);
  end

  // Stage 4: output code
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dac_q <= OW'(MID);
    end else if (en) begin
      dac_q <= code_d;
    end
  end

endmodule

// File: rtl/qdds_core.sv
module qdds_core
  import qdds_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int PH_W  = 12,
  parameter int SW    = 10,
  parameter int AW    = 10,
  parameter int OW    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              fsel,
  input  logic [ACC_W-1:0]  fword0,
  input  logic [ACC_W-1:0]  fword1,
  input  logic [PH_W-1:0]   phase_off,
  input  logic [2*AW-1:0]   iq_amp,
  output logic [OW-1:0]     dac_code
);

  localparam int IQ_W = 2 * AW;

  // Named internal events for the checker
  logic                 run_en;
  logic [ACC_W-1:0]     acc_q;
  logic [PH_W-1:0]      addr_q;
  logic signed [SW-1:0] sin_q;
  logic signed [SW-1:0] cos_q;
  logic [AW-1:0]        amp_sine;
  logic [AW-1:0]        amp_cosine;
  logic                 sat_hi;
  logic                 sat_lo;

  assign run_en     = ~sleep;
  assign amp_sine   = iq_amp[IQ_W-1 -: AW];
  assign amp_cosine = iq_amp[AW-1:0];

  qdds_phase_acc #(
    .ACC_W (ACC_W),
    .PH_W  (PH_W)
  ) acc_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (run_en),
    .fsel   (fsel),
    .fw0    (fword0),
    .fw1    (fword1),
    .ph_off (phase_off),
    .acc_q  (acc_q),
    .addr_q (addr_q)
  );

  qdds_sincos_lut #(
    .PH_W (PH_W),
    .SW   (SW)
  ) lut_i (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (run_en),
    .addr  (addr_q),
    .sin_q (sin_q),
    .cos_q (cos_q)
  );

  qdds_iq_mix #(
    .SW (SW),
    .AW (AW),
    .OW (OW)
  ) mix_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (run_en),
    .sin_in (sin_q),
    .cos_in (cos_q),
    .amp_s  (amp_sine),
    .amp_c  (amp_cosine),
    .dac_q  (dac_code),
    .sat_hi (sat_hi),
    .sat_lo (sat_lo)
  );

endmodule

// File: rtl/qdds_core_chk.sv
module qdds_core_chk #(
  parameter int ACC_W = 32,
  parameter int AW    = 10,
  parameter int OW    = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep,
  input logic              fsel,
  input logic [ACC_W-1:0]  fword0,
  input logic [ACC_W-1:0]  fword1,
  input logic [2*AW-1:0]   iq_amp,
  input logic [ACC_W-1:0]  acc_q,
  input logic              sat_hi,
  input logic              sat_lo,
  input logic [OW-1:0]     dac_code
);

  localparam logic [OW-1:0] CODE_MAX = '1;
  localparam logic [OW-1:0] CODE_MIN = '0;
  localparam logic [OW-1:0] CODE_MID = OW'(1 << (OW - 1));

  // R2
  zero_step_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !fsel && fword0 == '0) |=> $stable(acc_q));

  // R2
  zero_step_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && fsel && fword1 == '0) |=> $stable(acc_q));

  // R10
  sleep_acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(acc_q));

  // R10
  sleep_out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(dac_code));

  // R7
  clip_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_hi && !sleep) |=> (dac_code == CODE_MAX));

  // R7
  clip_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_lo && !sleep) |=> (dac_code == CODE_MIN));

  // R7
  clip_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sat_hi, sat_lo}));

  // R8
  zero_amp_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iq_amp == '0 && !sleep) ##1 !sleep |=> (dac_code == CODE_MID));

endmodule

bind qdds_core qdds_core_chk #(
  .ACC_W (ACC_W),
  .AW    (AW),
  .OW    (OW)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .sleep    (sleep),
  .fsel     (fsel),
  .fword0   (fword0),
  .fword1   (fword1),
  .iq_amp   (iq_amp),
  .acc_q    (acc_q),
  .sat_hi   (sat_hi),
  .sat_lo   (sat_lo),
  .dac_code (dac_code)
);

// File: tb/qdds_core_tb_top.sv
`timescale 1ns/1ps
module qdds_core_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sleep = 1'b0;
  logic        fsel = 1'b0;
  logic [31:0] f0 = '0;
  logic [31:0] f1 = '0;
  logic [11:0] ph = '0;
  logic [19:0] amp = '0;
  logic [9:0]  dac;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  qdds_core dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep     (sleep),
    .fsel      (fsel),
    .fword0    (f0),
    .fword1    (f1),
    .phase_off (ph),
    .iq_amp    (amp),
    .dac_code  (dac)
  );

  // Reference model state
  int          qt [1024];
  logic [31:0] macc;
  logic [11:0] maddr;
  int          msin, mcos, mas, mac, mout;

  function automatic int b_quarter(int k);
    longint h, u, a, num, den;
    h = 4096; u = 2 * k + 1; a = u * (h - u);
    num = 16 * 511 * a;
    den = 5 * h * h - 4 * a;
    return int'((num + den / 2) / den);
  endfunction

  function automatic int b_lut(logic [11:0] ad);
    int k;
    k = int'(ad[9:0]);
    case (ad[11:10])
      2'd0: return qt[k];
      2'd1: return qt[1023 - k];
      2'd2: return -qt[k];
      default: return -qt[1023 - k];
    endcase
  endfunction

  function automatic int b_out(int s, int c, int as, int ac);
    longint n, y;
    n = longint'(s) * as + longint'(c) * ac + 256;
    if (n >= 0) y = n / 512;
    else y = -((-n + 511) / 512);
    if (y > 511) y = 511;
    if (y < -512) y = -512;
    return int'(y) + 512;
  endfunction

  task automatic step();
    @(posedge clk);
    if (!rst_n) begin
      macc = '0; maddr = '0; msin = 0; mcos = 0; mas = 0; mac = 0; mout = 512;
    end else if (!sleep) begin
      mout  = b_out(msin, mcos, mas, mac);
      msin  = b_lut(maddr);
      mcos  = b_lut(maddr + 12'd1024);
      mas   = int'($signed(amp[19:10]));
      mac   = int'($signed(amp[9:0]));
      maddr = macc[31:20] + ph;
      macc  = macc + (fsel ? f1 : f0);
    end
    @(negedge clk);
  endtask

  task automatic chk(string tag, int exp);
    total++;
    if (dac !== exp[9:0]) begin
      bad++;
      $display("FAIL %s: dac_code actual=%0d expected=%0d", tag, dac, exp);
    end
  endtask

  task automatic settle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; f0 = '0; f1 = '0; fsel = 1'b0; ph = '0; sleep = 1'b0;
    step();
    rst_n = 1'b1;
  endtask

  // {toggle, fsel, fword0, fword1, phase_off, iq_amp, cycles}
  localparam int VW = 106;
  localparam int NV = 8;
  localparam logic [VW-1:0] VECS [NV] = '{
    {1'b0, 1'b0, 32'h0100_0000, 32'h0000_0000, 12'h000, {10'd0,   10'd511}, 8'd40},
    {1'b0, 1'b1, 32'h0000_0000, 32'h0123_4567, 12'h100, {10'd511, 10'd0},   8'd40},
    {1'b1, 1'b0, 32'h0800_0000, 32'h0040_0000, 12'h7FF, {10'd300, 10'h2F0}, 8'd40},
    {1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 12'hABC, {10'h200, 10'h200}, 8'd30},
    {1'b0, 1'b0, 32'h1000_0000, 32'h0000_0000, 12'h000, {10'd511, 10'd511}, 8'd30},
    {1'b1, 1'b1, 32'h3333_3333, 32'hC000_0000, 12'h400, {10'd128, 10'h380}, 8'd40},
    {1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000, 12'hFFF, 20'h00000,           8'd10},
    {1'b0, 1'b1, 32'h0000_0000, 32'hDEAD_BEEF, 12'h555, {10'd200, 10'd200}, 8'd40}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R10: watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 1024; k++) qt[k] = b_quarter(k);

    // R1: reset state and zero start phase
    repeat (3) step();
    chk("R1", 512);
    rst_n = 1'b1;
    amp = {10'd0, 10'd511};
    settle(4);
    chk("R1", 1022);

    // R9: select pulse reaches the output after 4 clocks
    f1 = 32'h4000_0000; fsel = 1'b1;
    step(); fsel = 1'b0;
    chk("R9", 1022);
    step(); chk("R9", 1022);
    step(); chk("R9", 1022);
    step(); chk("R9", 512);

    // R9: phase offset reaches the output after 3 clocks
    ph = 12'd3072;
    step(); chk("R9", 512);
    step(); chk("R9", 512);
    step(); chk("R9", 1022);

    // R10: sleep freezes everything
    sleep = 1'b1; fsel = 1'b1; ph = 12'd0;
    for (int i = 0; i < 6; i++) begin
      step(); chk("R10", 1022);
    end
    sleep = 1'b0; fsel = 1'b0;
    step(); chk("R10", 1022);
    step(); chk("R10", 1022);
    step(); chk("R10", 512);
    ph = 12'd3072;
    settle(3); chk("R10", 1022);

    // R3, R4, R5, R6, R7, R8 from a zero phase
    do_reset();
    amp = {10'd0, 10'd511}; ph = 12'd2048; settle(5); chk("R3", 2);
    amp = {10'd511, 10'd0}; ph = 12'd0;    settle(5); chk("R4", 512);
    ph = 12'd1024; settle(5); chk("R4", 1022);
    ph = 12'd3072; settle(5); chk("R4", 2);
    amp = {10'd0, 10'd511}; ph = 12'd0; settle(5); chk("R5", 1022);
    amp = {10'd511, 10'd0}; settle(5); chk("R5", 512);
    amp = {10'd0, 10'h200}; settle(5); chk("R6", 1);
    amp = {10'd0, 10'd1};   settle(5); chk("R8", 513);
    amp = 20'h0;            settle(5); chk("R8", 512);
    ph = 12'd512; amp = {10'd511, 10'd511}; settle(5); chk("R7", 1023);
    amp = {10'h200, 10'h200}; settle(5); chk("R7", 0);

    // R2: vector walk against the reference model
    for (int v = 0; v < NV; v++) begin
      logic [VW-1:0] row;
      row = VECS[v];
      f0 = row[103:72]; f1 = row[71:40]; ph = row[39:28]; amp = row[27:8];
      for (int c = 0; c < int'(row[7:0]); c++) begin
        fsel = row[105] ? (row[104] ^ c[0]) : row[104];
        step();
        chk("R2", mout);
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule